// File: doc/BRIEF.md
# Bus-Wide Configurable Logic Wordblock

This block is a coarse-grained programmable cell that works on whole N-bit buses at once. It holds N identical bit-slices. Slice i reads bit i of three input buses and looks its result up in an 8-entry truth table. One shared configuration word programs every slice, so every bit position computes the same function. The slice results then pass through a configurable zero-fill shifter before they reach the output bus.

The configuration word is loaded serially through a one-bit port while a load-enable is high. A control bit from a separate control block can swap the truth table for its complement when the configuration allows it. A status bit goes back to that control block and reports whether any bit of the output bus is set. The datapath from the input buses to the outputs is purely combinational and has no feedback path. An unprogrammed block therefore cannot form a combinational loop. The outputs are not meaningful while a load is in progress.

Top module: `bus_wordblock`

## Requirements
- R1: While reset is asserted and after it is released with no load, the configuration word is all zero, so `bus_y` and `status_out` are 0 for any bus inputs.
- R2: On each rising clock edge with `cfg_en` high, the configuration word shifts up by one and `cfg_din` enters bit 0. After CFG_W edges the word equals the bits sent, most significant first. Layout for WIDTH=8 (CFG_W=13): bits 7:0 truth table, bits 10:8 shift amount, bit 11 direction (0 = toward MSB, 1 = toward LSB), bit 12 control enable.
- R3: With `cfg_en` low, `cfg_din` is ignored and the configuration word holds its value.
- R4: Before shifting, slice i outputs truth-table bit number {a[i],b[i],c[i]}, with bus_a as the index MSB and bus_c as the LSB.
- R5: Every bit position uses the same truth table. Equal input triples at different positions give equal slice outputs.
- R6: With direction 0 and amount k, `bus_y` is the slice result shifted k places toward the MSB, and the k low bits are filled with zero.
- R7: With direction 1 and amount k, `bus_y` is the slice result shifted k places toward the LSB, and the k high bits are filled with zero. Amounts of WIDTH or more give zero.
- R8: With amount 0, `bus_y` equals the slice result unchanged.
- R9: When the control-enable bit is 1 and `ctrl_in` is 1, every slice uses the bitwise complement of the truth table.
- R10: When the control-enable bit is 0, `ctrl_in` has no effect on `bus_y`.
- R11: `status_out` is 1 exactly when at least one bit of `bus_y` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_en | input | 1 | Serial configuration shift enable |
| cfg_din | input | 1 | Serial configuration data, most significant bit first |
| ctrl_in | input | 1 | Control bit from the control block |
| bus_a | input | WIDTH | Input bus, truth-table index MSB |
| bus_b | input | WIDTH | Input bus, truth-table index middle bit |
| bus_c | input | WIDTH | Input bus, truth-table index LSB |
| bus_y | output | WIDTH | Shifted result bus |
| status_out | output | 1 | OR of all bits of bus_y, to the control block |

## Verification
On every cycle, the assertions check several rules. The configuration holds when loading is off, and each load edge moves in exactly one new bit. A zero shift amount passes the slice result straight through. The vacated edge bit is zero after a non-zero shift in either direction. The status bit agrees with the output bus. Only the bench scenarios can show the functional mapping: the truth-table indexing order, the identical function across all bit positions, the complement under the control bit and its absence when control is disabled, and the exact shifted values. The bench compares all of these against an independent model over random configurations and directed corners.

// File: rtl/wb_pkg.sv
package wb_pkg;
  // Truth table size for a three-input bit-slice.
  localparam int unsigned TT_W = 8;

  typedef enum logic {
    SH_TOWARD_MSB = 1'b0,
    SH_TOWARD_LSB = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/wb_rst_sync.sv
module wb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/wb_cfg_chain.sv
module wb_cfg_chain #(
  parameter int unsigned CFG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic [CFG_W-1:0] cfg_word
);
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  // next-state: shift one bit in at the bottom while loading
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_en) begin
      cfg_d = {cfg_q[CFG_W-2:0], cfg_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_word = cfg_q;

  // R3: idle load port leaves the word untouched
  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_word));

  // R2: a load edge moves the old word up and takes the new serial bit
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (cfg_word[0] == $past(cfg_din)) &&
               (cfg_word[CFG_W-1:1] == $past(cfg_word[CFG_W-2:0])));
endmodule

// File: rtl/wb_slice_array.sv
module wb_slice_array
  import wb_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [TT_W-1:0]  truth_tbl,
  input  logic             ctl_en,
  input  logic             ctl_bit,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  output logic [WIDTH-1:0] slice_out
);
  logic [TT_W-1:0] tt_eff;

  // control-block override swaps in the complemented table
  always_comb begin
    tt_eff = truth_tbl;
    if (ctl_en && ctl_bit) begin
      tt_eff = ~truth_tbl;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic [2:0] idx;
    assign idx          = {in_a[i], in_b[i], in_c[i]};
    assign slice_out[i] = tt_eff[idx];
  end
endmodule

// File: rtl/wb_shifter.sv
module wb_shifter
  import wb_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SHW   = 3
) (
  input  shift_dir_e       dir,
  input  logic [SHW-1:0]   amt,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             any_set
);
  logic [WIDTH-1:0] stage [SHW+1];

  assign stage[0] = din;

  // logarithmic barrel: stage k moves by 2**k when amt[k] is set
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    logic [WIDTH-1:0] moved;
    always_comb begin
      if (dir == SH_TOWARD_LSB) begin
        moved = stage[k] >> STEP;
      end else begin
        moved = stage[k] << STEP;
      end
    end
    assign stage[k+1] = amt[k] ? moved : stage[k];
  end

  assign dout    = stage[SHW];
  assign any_set = |stage[SHW];
endmodule

// File: rtl/bus_wordblock.sv
module bus_wordblock
  import wb_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic             ctrl_in,
  input  logic [WIDTH-1:0] bus_a,
  input  logic [WIDTH-1:0] bus_b,
  input  logic [WIDTH-1:0] bus_c,
  output logic [WIDTH-1:0] bus_y,
  output logic             status_out
);
  localparam int unsigned SHW      = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int unsigned AMT_LSB  = TT_W;
  localparam int unsigned DIR_POS  = TT_W + SHW;
  localparam int unsigned CEN_POS  = TT_W + SHW + 1;
  localparam int unsigned CFG_W    = TT_W + SHW + 2;

  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg_word;
  logic [TT_W-1:0]  cfg_tt;
  logic [SHW-1:0]   cfg_amt;
  shift_dir_e       cfg_dir;
  logic             cfg_ctl_en;
  logic [WIDTH-1:0] slice_y;

  wb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wb_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .cfg_word (cfg_word)
  );

  // field decode of the shared configuration word
  assign cfg_tt     = cfg_word[TT_W-1:0];
  assign cfg_amt    = cfg_word[AMT_LSB +: SHW];
  assign cfg_dir    = shift_dir_e'(cfg_word[DIR_POS]);
  assign cfg_ctl_en = cfg_word[CEN_POS];

  wb_slice_array #(.WIDTH(WIDTH)) u_slices (
    .truth_tbl (cfg_tt),
    .ctl_en    (cfg_ctl_en),
    .ctl_bit   (ctrl_in),
    .in_a      (bus_a),
    .in_b      (bus_b),
    .in_c      (bus_c),
    .slice_out (slice_y)
  );

  wb_shifter #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
    .dir     (cfg_dir),
    .amt     (cfg_amt),
    .din     (slice_y),
    .dout    (bus_y),
    .any_set (status_out)
  );

  // R8: zero shift amount is a straight pass-through
  a_r8_pass_through: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_amt == '0) |-> (bus_y == slice_y));

  // R6: shifting toward the MSB empties bit 0
  a_r6_low_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cfg_dir == SH_TOWARD_MSB) && (cfg_amt != '0)) |-> (bus_y[0] == 1'b0));

  // R7: shifting toward the LSB empties the top bit
  a_r7_high_fill: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cfg_dir == SH_TOWARD_LSB) && (cfg_amt != '0)) |-> (bus_y[WIDTH-1] == 1'b0));

  // R11: status agrees with the result bus
  a_r11_status: assert property (@(posedge clk) disable iff (!rst_sync_n)
    status_out == ($countones(bus_y) != 0));

  // R1: during reset release the configuration is still clear
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_sync_n |-> (cfg_word == '0));
endmodule

// File: tb/sim_bus_wordblock.sv
module sim_bus_wordblock;
  localparam int unsigned W   = 8;
  localparam int unsigned SHW = 3;
  localparam int unsigned CW  = 8 + SHW + 2;

  logic         clk;
  logic         rst_n;
  logic         cfg_en;
  logic         cfg_din;
  logic         ctrl_in;
  logic [W-1:0] bus_a;
  logic [W-1:0] bus_b;
  logic [W-1:0] bus_c;
  logic [W-1:0] bus_y;
  logic         status_out;

  int n_checks;
  int n_fail;

  bus_wordblock #(.WIDTH(W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_din    (cfg_din),
    .ctrl_in    (ctrl_in),
    .bus_a      (bus_a),
    .bus_b      (bus_b),
    .bus_c      (bus_c),
    .bus_y      (bus_y),
    .status_out (status_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // configuration word builder per the R2 layout
  function automatic logic [CW-1:0] mk_cfg(logic cen, logic dir, logic [SHW-1:0] amt,
                                           logic [7:0] tt);
    return {cen, dir, amt, tt};
  endfunction

  // independent model of R4..R10
  function automatic logic [W-1:0] model(logic [CW-1:0] w, logic ci,
                                         logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [7:0]     tt;
    logic [SHW-1:0] amt;
    logic [W-1:0]   s;
    tt  = w[7:0];
    amt = w[8 +: SHW];
    if (w[CW-1] && ci) tt = ~tt;
    for (int i = 0; i < W; i++) s[i] = tt[{a[i], b[i], c[i]}];
    if (w[CW-2]) return s >> amt;
    return s << amt;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_status(string req);
    check(req, {{(W-1){1'b0}}, status_out}, {{(W-1){1'b0}}, (bus_y != '0)});
  endtask

  task automatic load_cfg(logic [CW-1:0] w);
    for (int k = CW - 1; k >= 0; k--) begin
      @(negedge clk);
      cfg_en  = 1'b1;
      cfg_din = w[k];
    end
    @(negedge clk);
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
  endtask

  task automatic apply(logic ci, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    ctrl_in = ci;
    bus_a   = a;
    bus_b   = b;
    bus_c   = c;
    #1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    logic [CW-1:0] w;
    n_checks = 0;
    n_fail   = 0;
    void'($urandom(32'd5179));
    rst_n   = 1'b0;
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
    apply(1'b1, 8'hA5, 8'h3C, 8'hFF);
    repeat (3) @(negedge clk);
    // R1: cleared configuration drives zero
    check("R1 reset bus_y", bus_y, '0);
    check("R1 reset status", {7'd0, status_out}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(1'b0, 8'hFF, 8'h0F, 8'h55);
    check("R1 post-reset bus_y", bus_y, '0);

    // R4: identity of each index, one table bit at a time
    for (int t = 0; t < 8; t++) begin
      w = mk_cfg(1'b0, 1'b0, '0, 8'(1 << t));
      load_cfg(w);
      apply(1'b0, 8'b1111_0000, 8'b1100_1100, 8'b1010_1010);
      check("R4 index order", bus_y, model(w, 1'b0, 8'hF0, 8'hCC, 8'hAA));
    end

    // R5: same triple everywhere gives a uniform bus
    w = mk_cfg(1'b0, 1'b0, '0, 8'b0100_0000);
    load_cfg(w);
    apply(1'b0, 8'hFF, 8'hFF, 8'h00);
    check("R5 uniform function", bus_y, 8'hFF);

    // R8: amount zero with majority function
    w = mk_cfg(1'b0, 1'b1, '0, 8'hE8);
    load_cfg(w);
    apply(1'b0, 8'h96, 8'h5A, 8'h33);
    check("R8 pass-through", bus_y, model(w, 1'b0, 8'h96, 8'h5A, 8'h33));

    // R6: max shift toward MSB
    w = mk_cfg(1'b0, 1'b0, 3'd7, 8'hFF);
    load_cfg(w);
    apply(1'b0, 8'h00, 8'h00, 8'h00);
    check("R6 left max", bus_y, 8'h80);

    // R7: max shift toward LSB
    w = mk_cfg(1'b0, 1'b1, 3'd7, 8'hFF);
    load_cfg(w);
    check("R7 right max", bus_y, 8'h01);
    check_status("R11 status one bit");

    // R3: toggle cfg_din with load disabled; config must hold
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      cfg_din = ~cfg_din;
    end
    #1;
    check("R3 hold on idle", bus_y, 8'h01);

    // R9 / R10: control bit with and without enable
    w = mk_cfg(1'b1, 1'b0, 3'd1, 8'h96);
    load_cfg(w);
    apply(1'b1, 8'h3A, 8'hC5, 8'h0F);
    check("R9 complement", bus_y, model(w, 1'b1, 8'h3A, 8'hC5, 8'h0F));
    w = mk_cfg(1'b0, 1'b0, 3'd1, 8'h96);
    load_cfg(w);
    apply(1'b1, 8'h3A, 8'hC5, 8'h0F);
    check("R10 ctrl ignored", bus_y, model(w, 1'b0, 8'h3A, 8'hC5, 8'h0F));

    // R11: zero result clears status
    w = mk_cfg(1'b0, 1'b0, 3'd2, 8'h00);
    load_cfg(w);
    check_status("R11 status zero");

    // R2: random configurations loaded serially, checked via outputs
    for (int n = 0; n < 150; n++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      logic [W-1:0] c;
      logic         ci;
      w  = CW'($urandom);
      a  = W'($urandom);
      b  = W'($urandom);
      c  = W'($urandom);
      ci = 1'($urandom);
      load_cfg(w);
      apply(ci, a, b, c);
      check("R2 random load/R6/R7", bus_y, model(w, ci, a, b, c));
      check_status("R11 random status");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule